// File: doc/BRIEF.md
# Processor control register file

This block keeps the three live control registers of a 32-bit protected-mode processor: the machine control word (register 0), the page-fault address register (register 2) and the page-directory base register (register 3). The execute stage moves data in and out of them through one access port: a 2-bit register number, a valid strobe, a write flag, 32-bit write data and a combinational read result. Writes are checked before they are stored. An illegal combination of mode bits is refused, and register number 1 is a hole that traps on any access.

Other parts of the core use the state directly. The page walker reports faults, and the block latches the faulting linear address. Each write of the directory base sends a one-cycle flush to the translation cache. The task-switch logic sets the task-switched flag. The floating-point issue logic asks whether a floating-point or WAIT instruction may proceed, and the block answers with a device-not-available signal or an emulation trap. A 2-bit mode output tells the rest of the core whether it runs in real mode, in protected mode without paging, or in protected mode with paging.

Top module: `ctrl_reg_file`

## Requirements
- R1: After reset, register 0 holds zero except bit 4, which takes the value of `fpu_new_strap`. Registers 2 and 3 read zero, `mode` is 2'b00 and every fault and flush strobe is low.
- R2: A write to register 0 stores bit 0 (protection enable), bit 1 (monitor coprocessor), bit 2 (emulate), bit 3 (task switched), bit 4 (coprocessor type) and bit 31 (paging enable). All other bits are stored as zero.
- R3: A write to register 0 whose data has bit 31 set and bit 0 clear leaves register 0 unchanged. In the following cycle it raises `gp_fault` for exactly one cycle.
- R4: An access to register number 1, read or write, raises `ud_fault` for one cycle in the following cycle. It changes no register, and `rd_data` reads zero while `acc_sel` is 1.
- R5: Register 3 stores write bits 31:12 and reads bits 11:0 as zero. It accepts writes in every mode.
- R6: Every write to register 3, including one that repeats the stored value, raises `xlat_flush` for exactly one cycle in the following cycle. No other access raises it.
- R7: When `pf_valid` is high, `pf_addr` is stored in register 2. This takes priority over a write to register 2 in the same cycle, and register 2 is otherwise written normally.
- R8: `task_switch` sets bit 3 of register 0. It wins over a register 0 write in the same cycle, whether that write is stored or refused.
- R9: With bit 2 set, `fp_issue` raises `emu_trap` and does not raise `dev_na` on its own account. With bit 2 clear, `fp_issue` raises `dev_na` exactly when bit 3 is set. Both outputs are combinational.
- R10: `wait_issue` raises `dev_na` exactly when bits 1 and 3 are both set. It never raises `emu_trap`.
- R11: `mode` is 2'b00 when bit 0 is clear, 2'b01 when bit 0 is set and bit 31 is clear, and 2'b11 when both are set. It never reads 2'b10.
- R12: `rd_data` always shows the register selected by `acc_sel` (0, 1, 2 or 3), whether or not `acc_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fpu_new_strap | input | 1 | Coprocessor type strap, sampled during reset |
| acc_valid | input | 1 | Register move request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | Register number |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Selected register value |
| pf_valid | input | 1 | Page fault report |
| pf_addr | input | 32 | Faulting linear address |
| task_switch | input | 1 | Task switch event |
| fp_issue | input | 1 | Floating-point instruction issue |
| wait_issue | input | 1 | WAIT instruction issue |
| dev_na | output | 1 | Device-not-available exception |
| emu_trap | output | 1 | Floating-point emulation trap |
| gp_fault | output | 1 | General-protection fault strobe |
| ud_fault | output | 1 | Invalid-opcode fault strobe |
| xlat_flush | output | 1 | Translation-cache flush strobe |
| mode | output | 2 | Operating mode |

## Verification
The hardest cases to reach are collisions in a single cycle. One is a refused paging-without-protection write that lands together with a task switch, where the flag must still be set while paging and protection stay untouched. Another is a page-fault report that lands on a register 2 write. Directed steps drive each collision once, with values chosen so that the winner is visible on the read port. A long random phase then mixes register numbers, write data with the two protection bits in all four combinations, task switches and fault reports. Every cycle it is compared against a behavioural model.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;
  localparam int XLEN       = 32;
  localparam int PAGE_SHIFT = 12;

  localparam int B_PE = 0;
  localparam int B_MP = 1;
  localparam int B_EM = 2;
  localparam int B_TS = 3;
  localparam int B_ET = 4;
  localparam int B_PG = XLEN - 1;

  typedef enum logic [1:0] {
    SEL_MCW  = 2'd0,
    SEL_HOLE = 2'd1,
    SEL_PFA  = 2'd2,
    SEL_PDB  = 2'd3
  } creg_sel_e;

  typedef enum logic [1:0] {
    MODE_REAL  = 2'b00,
    MODE_PROT  = 2'b01,
    MODE_PAGED = 2'b11
  } op_mode_e;
endpackage

// File: rtl/mcw_unit.sv
module mcw_unit
  import ctrlreg_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         et_strap,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         task_switch,
  output logic [W-1:0] mcw_q,
  output logic         gp_fault
);
  localparam logic [W-1:0] KEEP_MASK =
    (W'(1) << B_PE) | (W'(1) << B_MP) | (W'(1) << B_EM) |
    (W'(1) << B_TS) | (W'(1) << B_ET) | (W'(1) << (W - 1));

  logic         bad_combo;
  logic         wr_ok;
  logic         upd_en;
  logic [W-1:0] mcw_d;
  logic         gp_d;

  always_comb begin
    bad_combo = wdata[W-1] & ~wdata[B_PE];
    wr_ok     = wr_en & ~bad_combo;
    gp_d      = wr_en & bad_combo;
    upd_en    = wr_ok | task_switch;
    mcw_d     = mcw_q;
    if (wr_ok) mcw_d = wdata & KEEP_MASK;
    if (task_switch) mcw_d[B_TS] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcw_q         <= '0;
      mcw_q[B_ET]   <= et_strap;
      gp_fault      <= 1'b0;
    end else begin
      gp_fault <= gp_d;
      if (upd_en) mcw_q <= mcw_d;
    end
  end
endmodule

// File: rtl/paging_regs.sv
module paging_regs
  import ctrlreg_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int SHIFT = PAGE_SHIFT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pfa_wr,
  input  logic         pdb_wr,
  input  logic [W-1:0] wdata,
  input  logic         pf_valid,
  input  logic [W-1:0] pf_addr,
  output logic [W-1:0] pfa_q,
  output logic [W-1:0] pdb_q,
  output logic         xlat_flush
);
  localparam int FRAME_W = W - SHIFT;

  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;
  logic [W-1:0]       pfa_d;
  logic               pfa_en;

  always_comb begin
    pfa_en  = pfa_wr | pf_valid;
    pfa_d   = pf_valid ? pf_addr : wdata;
    frame_d = wdata[W-1:SHIFT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfa_q      <= '0;
      frame_q    <= '0;
      xlat_flush <= 1'b0;
    end else begin
      xlat_flush <= pdb_wr;
      if (pfa_en) pfa_q   <= pfa_d;
      if (pdb_wr) frame_q <= frame_d;
    end
  end

  assign pdb_q = {frame_q, {SHIFT{1'b0}}};
endmodule

// File: rtl/fpu_gate.sv
module fpu_gate (
  input  logic mp,
  input  logic em,
  input  logic ts,
  input  logic fp_issue,
  input  logic wait_issue,
  output logic dev_na,
  output logic emu_trap
);
  always_comb begin
    emu_trap = fp_issue & em;
    dev_na   = (fp_issue & ~em & ts) | (wait_issue & mp & ts);
  end
endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
  import ctrlreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fpu_new_strap,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_sel,
  input  logic [31:0] acc_wdata,
  output logic [31:0] rd_data,
  input  logic        pf_valid,
  input  logic [31:0] pf_addr,
  input  logic        task_switch,
  input  logic        fp_issue,
  input  logic        wait_issue,
  output logic        dev_na,
  output logic        emu_trap,
  output logic        gp_fault,
  output logic        ud_fault,
  output logic        xlat_flush,
  output logic [1:0]  mode
);
  logic [XLEN-1:0] mcw_q;
  logic [XLEN-1:0] pfa_q;
  logic [XLEN-1:0] pdb_q;
  logic            wr_any;
  logic            mcw_wr;
  logic            pfa_wr;
  logic            pdb_wr;
  logic            hole_hit;
  logic            ud_d;

  always_comb begin
    wr_any   = acc_valid & acc_write;
    mcw_wr   = wr_any & (acc_sel == SEL_MCW);
    pfa_wr   = wr_any & (acc_sel == SEL_PFA);
    pdb_wr   = wr_any & (acc_sel == SEL_PDB);
    hole_hit = acc_valid & (acc_sel == SEL_HOLE);
    ud_d     = hole_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ud_fault <= 1'b0;
    else        ud_fault <= ud_d;
  end

  mcw_unit #(.W(XLEN)) u_mcw (
    .clk         (clk),
    .rst_n       (rst_n),
    .et_strap    (fpu_new_strap),
    .wr_en       (mcw_wr),
    .wdata       (acc_wdata),
    .task_switch (task_switch),
    .mcw_q       (mcw_q),
    .gp_fault    (gp_fault)
  );

  paging_regs #(.W(XLEN), .SHIFT(PAGE_SHIFT)) u_pg (
    .clk        (clk),
    .rst_n      (rst_n),
    .pfa_wr     (pfa_wr),
    .pdb_wr     (pdb_wr),
    .wdata      (acc_wdata),
    .pf_valid   (pf_valid),
    .pf_addr    (pf_addr),
    .pfa_q      (pfa_q),
    .pdb_q      (pdb_q),
    .xlat_flush (xlat_flush)
  );

  fpu_gate u_fpu (
    .mp         (mcw_q[B_MP]),
    .em         (mcw_q[B_EM]),
    .ts         (mcw_q[B_TS]),
    .fp_issue   (fp_issue),
    .wait_issue (wait_issue),
    .dev_na     (dev_na),
    .emu_trap   (emu_trap)
  );

  always_comb begin
    unique case (acc_sel)
      SEL_MCW: rd_data = mcw_q;
      SEL_PFA: rd_data = pfa_q;
      SEL_PDB: rd_data = pdb_q;
      default: rd_data = '0;
    endcase
  end

  always_comb begin
    if (!mcw_q[B_PE])     mode = MODE_REAL;
    else if (mcw_q[B_PG]) mode = MODE_PAGED;
    else                  mode = MODE_PROT;
  end
endmodule

// File: rtl/ctrl_reg_file_chk.sv
module ctrl_reg_file_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [1:0]  acc_sel,
  input logic [31:0] acc_wdata,
  input logic        task_switch,
  input logic        fp_issue,
  input logic        wait_issue,
  input logic        dev_na,
  input logic        emu_trap,
  input logic        gp_fault,
  input logic        ud_fault,
  input logic        xlat_flush,
  input logic [1:0]  mode,
  input logic [31:0] mcw_q,
  input logic [31:0] pdb_q
);
  a_r11_no_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b10);

  a_r3_refused_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> (mcw_q[31] == $past(mcw_q[31]) && mcw_q[0] == $past(mcw_q[0])));

  a_r3_refused_raises_gp: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_sel == 2'd0 && acc_wdata[31] && !acc_wdata[0])
      |=> gp_fault);

  a_r4_hole_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_sel == 2'd1) |=> (ud_fault && !gp_fault && !xlat_flush));

  a_r5_pdb_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pdb_q[11:0] == 12'h000);

  a_r6_flush_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_sel == 2'd3) |=> xlat_flush);

  a_r6_flush_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_flush |-> $past(acc_valid && acc_write && acc_sel == 2'd3));

  a_r8_switch_sets_ts: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> mcw_q[3]);

  a_r10_wait_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_issue && !fp_issue && !(mcw_q[1] && mcw_q[3])) |-> !dev_na);

  a_r9_emu_needs_fp: assert property (@(posedge clk) disable iff (!rst_n)
    emu_trap |-> (fp_issue && mcw_q[2]));
endmodule

bind ctrl_reg_file ctrl_reg_file_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_sel     (acc_sel),
  .acc_wdata   (acc_wdata),
  .task_switch (task_switch),
  .fp_issue    (fp_issue),
  .wait_issue  (wait_issue),
  .dev_na      (dev_na),
  .emu_trap    (emu_trap),
  .gp_fault    (gp_fault),
  .ud_fault    (ud_fault),
  .xlat_flush  (xlat_flush),
  .mode        (mode),
  .mcw_q       (mcw_q),
  .pdb_q       (pdb_q)
);

// File: tb/tb_ctrl_reg_file.sv
`timescale 1ns/1ps
module tb_ctrl_reg_file;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fpu_new_strap;
  logic        acc_valid, acc_write;
  logic [1:0]  acc_sel;
  logic [31:0] acc_wdata;
  logic [31:0] rd_data;
  logic        pf_valid;
  logic [31:0] pf_addr;
  logic        task_switch, fp_issue, wait_issue;
  logic        dev_na, emu_trap, gp_fault, ud_fault, xlat_flush;
  logic [1:0]  mode;

  always #5 clk = ~clk;

  ctrl_reg_file dut (
    .clk(clk), .rst_n(rst_n), .fpu_new_strap(fpu_new_strap),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .pf_valid(pf_valid),
    .pf_addr(pf_addr), .task_switch(task_switch), .fp_issue(fp_issue),
    .wait_issue(wait_issue), .dev_na(dev_na), .emu_trap(emu_trap),
    .gp_fault(gp_fault), .ud_fault(ud_fault), .xlat_flush(xlat_flush),
    .mode(mode)
  );

  integer checks = 0;
  integer errors = 0;

  // behavioural reference state
  logic [31:0] m_r0, m_r2, m_r3;
  logic        m_gp, m_ud, m_fl;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: return m_r0;
      2'd2: return m_r2;
      2'd3: return m_r3;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [1:0] m_mode();
    if (m_r0[0] == 1'b0) return 2'b00;
    return m_r0[31] ? 2'b11 : 2'b01;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r0 = {27'd0, fpu_new_strap, 4'd0};
      m_r2 = 0; m_r3 = 0; m_gp = 0; m_ud = 0; m_fl = 0;
    end else begin
      m_gp = 0; m_ud = 0; m_fl = 0;
      if (acc_valid && acc_sel == 2'd1) m_ud = 1;
      if (acc_valid && acc_write) begin
        if (acc_sel == 2'd0) begin
          if (acc_wdata[31] && !acc_wdata[0]) m_gp = 1;
          else m_r0 = {acc_wdata[31], 26'd0, acc_wdata[4:0]};
        end
        if (acc_sel == 2'd2) m_r2 = acc_wdata;
        if (acc_sel == 2'd3) begin
          m_r3 = {acc_wdata[31:12], 12'h000};
          m_fl = 1;
        end
      end
      if (pf_valid) m_r2 = pf_addr;
      if (task_switch) m_r0[3] = 1'b1;
    end
  end

  task automatic compare_all();
    logic e_dna, e_emu;
    e_emu = fp_issue && m_r0[2];
    e_dna = (fp_issue && !m_r0[2] && m_r0[3]) || (wait_issue && m_r0[1] && m_r0[3]);
    chk("R12 rd_data", rd_data, m_read(acc_sel));
    chk("R11 mode", {30'd0, mode}, {30'd0, m_mode()});
    chk("R3 gp_fault", {31'd0, gp_fault}, {31'd0, m_gp});
    chk("R4 ud_fault", {31'd0, ud_fault}, {31'd0, m_ud});
    chk("R6 xlat_flush", {31'd0, xlat_flush}, {31'd0, m_fl});
    chk("R9 R10 dev_na", {31'd0, dev_na}, {31'd0, e_dna});
    chk("R9 emu_trap", {31'd0, emu_trap}, {31'd0, e_emu});
  endtask

  task automatic step(input logic v, input logic w, input logic [1:0] s,
                      input logic [31:0] d, input logic pf, input logic [31:0] pa,
                      input logic ts, input logic fp, input logic wt);
    @(negedge clk);
    compare_all();
    acc_valid = v; acc_write = w; acc_sel = s; acc_wdata = d;
    pf_valid = pf; pf_addr = pa; task_switch = ts; fp_issue = fp; wait_issue = wt;
  endtask

  task automatic idle();
    step(0, 0, 2'd0, 32'h0, 0, 32'h0, 0, 0, 0);
  endtask

  task automatic peek(input logic [1:0] s, input logic [31:0] exp, input string tag);
    @(negedge clk);
    compare_all();
    acc_valid = 0; acc_write = 0; acc_sel = s; pf_valid = 0; task_switch = 0;
    fp_issue = 0; wait_issue = 0;
    #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; fpu_new_strap = 1;
    acc_valid = 0; acc_write = 0; acc_sel = 0; acc_wdata = 0;
    pf_valid = 0; pf_addr = 0; task_switch = 0; fp_issue = 0; wait_issue = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    peek(2'd0, 32'h0000_0010, "R1 reg0 after reset");
    chk("R1 mode after reset", {30'd0, mode}, 32'd0);
    peek(2'd3, 32'h0, "R1 reg3 after reset");

    // R2 write all ones, reserved forced to zero
    step(1, 1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    peek(2'd0, 32'h8000_001F, "R2 reg0 masked write");
    chk("R11 paged mode", {30'd0, mode}, 32'd3);

    // R9 R10 gating with MP EM TS all set
    step(0, 0, 2'd0, 0, 0, 0, 0, 1, 0);
    #1 chk("R9 emu trap with EM", {31'd0, emu_trap}, 32'd1);
    chk("R9 no dna with EM", {31'd0, dev_na}, 32'd0);
    step(0, 0, 2'd0, 0, 0, 0, 0, 0, 1);
    #1 chk("R10 wait dna with MP TS", {31'd0, dev_na}, 32'd1);

    // R3 paging without protection refused, collides with task switch
    step(1, 1, 2'd0, 32'h0000_0002, 0, 0, 0, 0, 0);
    step(1, 1, 2'd0, 32'h8000_0000, 0, 0, 1, 0, 0);
    idle();
    #1 chk("R3 gp strobe", {31'd0, gp_fault}, 32'd1);
    peek(2'd0, 32'h0000_000A, "R3 R8 refused keeps reg0, TS set");

    // R8 stored write with simultaneous task switch
    step(1, 1, 2'd0, 32'h0000_0001, 0, 0, 1, 0, 0);
    peek(2'd0, 32'h0000_0009, "R8 switch wins over write");
    step(0, 0, 2'd0, 0, 0, 0, 0, 1, 0);
    #1 chk("R9 fp dna when TS", {31'd0, dev_na}, 32'd1);
    step(0, 0, 2'd0, 0, 0, 0, 0, 0, 1);
    #1 chk("R10 wait no dna without MP", {31'd0, dev_na}, 32'd0);

    // R5 R6 directory base writes in real mode, repeated value
    step(1, 1, 2'd0, 32'h0, 0, 0, 0, 0, 0);
    step(1, 1, 2'd3, 32'h1234_5ABC, 0, 0, 0, 0, 0);
    step(1, 1, 2'd3, 32'h1234_5ABC, 0, 0, 0, 0, 0);
    idle();
    #1 chk("R6 flush on repeated write", {31'd0, xlat_flush}, 32'd1);
    peek(2'd3, 32'h1234_5000, "R5 reg3 low bits zero");

    // R4 hole access
    step(1, 1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    idle();
    #1 chk("R4 ud strobe", {31'd0, ud_fault}, 32'd1);
    peek(2'd1, 32'h0, "R4 hole reads zero");
    peek(2'd0, 32'h0, "R4 reg0 untouched");

    // R7 fault address beats a register 2 write
    step(1, 1, 2'd2, 32'h0000_0001, 1, 32'hDEAD_BEEF, 0, 0, 0);
    peek(2'd2, 32'hDEAD_BEEF, "R7 fault address wins");
    step(1, 1, 2'd2, 32'h0BAD_F00D, 0, 0, 0, 0, 0);
    peek(2'd2, 32'h0BAD_F00D, "R7 plain write");

    // random mix compared every cycle with the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           2'($urandom_range(0, 3)), d,
           $urandom_range(0, 9) == 0, $urandom,
           $urandom_range(0, 9) == 0,
           $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
    end
    idle();
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule